// File: doc/BRIEF.md
# Single-Cycle Twenty-Instruction Processor Core

This block is a complete single-cycle processor for a 32-bit, 32-register instruction subset of twenty operations. In every clock cycle it fetches the word addressed by the program counter from an internal instruction ROM, decodes the opcode and function fields into a set of ten control signals, reads two registers, drives the ALU, optionally reads or writes a small internal data RAM, writes the result back and selects the next program counter. The program counter counts instruction words, so sequential flow adds one.

The instruction ROM contents come from a parameter. An integrator fixes that parameter to the program the core has to run. Only debug outputs leave the block: the low bits of both register read ports and of the program counter, plus an overflow flag and a zero flag. Both flags come from the ALU's add/subtract unit for the instruction being executed.

Top module: `sc_core`

## Requirements
- R1: An asynchronous active-high reset clears the program counter and every register at once, without waiting for a clock edge. While it is held, `dbg_pc` reads 0.
- R2: Any instruction that is not a jump, and not a taken branch, loads PC+1. `dbg_pc` shows PC bits 3:0.
- R3: add, sub and slt (opcode 000000 with function 100000, 100010 and 101010) write rd. slt writes 1 when rs < rt as signed numbers, including when the subtraction overflows. `ovf_flag` is the signed overflow of the add/subtract unit. `zero_flag` is 1 when that unit's result is all zeros.
- R4: and, or, xor and nor (function 100100, 100101, 100110, 100111) write the bitwise result to rd.
- R5: Each immediate instruction writes rt. addi (001000) and slti (001010) sign-extend the 16-bit immediate. andi (001100), ori (001101) and xori (001110) zero-extend it. lui (001111) writes the immediate into bits 31:16 with zeros below.
- R6: Register 0 reads as zero, and writes to it are discarded.
- R7: sw (101011) stores rt at word address rs + sign-extended immediate, and lw (100011) loads rt from that address. Only sw writes the data RAM.
- R8: beq (000100), bne (000101) and bltz (000001, taken when rs bit 31 is 1) load PC + 1 + sign-extended immediate when taken. Otherwise they load PC+1.
- R9: j (000010) loads the zero-extended 26-bit target field. jr (opcode 000000, function 001000) loads the value of rs.
- R10: Any opcode or function code not listed here writes no register and no memory, and advances the PC by one.
- R11: `dbg_rs` and `dbg_rt` show bits 3:0 of the registers named by instruction bits 25:21 and 20:16 of the instruction being executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| dbg_rs | output | 4 | Low bits of the first register read port |
| dbg_rt | output | 4 | Low bits of the second register read port |
| dbg_pc | output | 4 | Low bits of the program counter |
| ovf_flag | output | 1 | Signed overflow of the add/subtract unit |
| zero_flag | output | 1 | Add/subtract unit result is zero |

## Verification
The bench runs one directed program through every instruction class. Each result is read back through the debug ports when a later instruction names that register.

The corner cases and what a wrong design would show:
- **xori with a set top immediate bit, followed by bltz.** Sign-extending where zero-extension is required makes the register negative, so the branch is taken and the PC sequence diverges.
- **Adding 1 to the largest positive value, then slt on the wrapped result.** A wrong overflow equation flips `ovf_flag`. An slt that uses only the sign of the difference writes 0 instead of 1, and a later read port shows that.
- **Writes to register 0 and unknown encodings.** These would leave nonzero values in places that later reads show as zero.
- **Reset asserted between clock edges.** A synchronous reset would leave the PC and the registers unchanged until the next edge.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN   = 32;
    localparam int ILEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_BLTZ  = 6'b000001;
    localparam logic [5:0] OP_J     = 6'b000010;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_BNE   = 6'b000101;
    localparam logic [5:0] OP_ADDI  = 6'b001000;
    localparam logic [5:0] OP_SLTI  = 6'b001010;
    localparam logic [5:0] OP_ANDI  = 6'b001100;
    localparam logic [5:0] OP_ORI   = 6'b001101;
    localparam logic [5:0] OP_XORI  = 6'b001110;
    localparam logic [5:0] OP_LUI   = 6'b001111;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;

    localparam logic [5:0] FN_JR  = 6'b001000;
    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_XOR = 6'b100110;
    localparam logic [5:0] FN_NOR = 6'b100111;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] { LG_AND, LG_OR, LG_XOR, LG_NOR } logic_op_e;
    typedef enum logic [1:0] { AF_UPPER, AF_SETLT, AF_ARITH, AF_LOGIC } alu_fn_e;
    typedef enum logic [1:0] { BR_NONE, BR_EQ, BR_NE, BR_LTZ } br_kind_e;
    typedef enum logic [1:0] { PS_SEQ, PS_JUMP, PS_REG, PS_RSVD } pc_src_e;

    typedef struct packed {
        logic      reg_write;
        logic      reg_dst;
        logic      reg_in_src;
        logic      alu_src;
        logic      add_sub;
        logic      data_write;
        logic_op_e logic_op;
        alu_fn_e   alu_fn;
        br_kind_e  br_kind;
        pc_src_e   pc_src;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    function automatic ctrl_t mk(input logic rw, input logic dst, input logic insrc,
                                 input logic asrc, input logic subt, input logic dw,
                                 input logic_op_e lf, input alu_fn_e fn,
                                 input br_kind_e br, input pc_src_e ps);
        ctrl_t c;
        c.reg_write  = rw;
        c.reg_dst    = dst;
        c.reg_in_src = insrc;
        c.alu_src    = asrc;
        c.add_sub    = subt;
        c.data_write = dw;
        c.logic_op   = lf;
        c.alu_fn     = fn;
        c.br_kind    = br;
        c.pc_src     = ps;
        return c;
    endfunction

    always_comb begin
        ctrl = '0;
        unique case (opcode)
            OP_RTYPE: begin
                unique case (funct)
                    FN_ADD: ctrl = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, LG_AND, AF_ARITH, BR_NONE, PS_SEQ);
                    FN_SUB: ctrl = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, LG_AND, AF_ARITH, BR_NONE, PS_SEQ);
                    FN_SLT: ctrl = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, LG_AND, AF_SETLT, BR_NONE, PS_SEQ);
                    FN_AND: ctrl = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, LG_AND, AF_LOGIC, BR_NONE, PS_SEQ);
                    FN_OR:  ctrl = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, LG_OR,  AF_LOGIC, BR_NONE, PS_SEQ);
                    FN_XOR: ctrl = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, LG_XOR, AF_LOGIC, BR_NONE, PS_SEQ);
                    FN_NOR: ctrl = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, LG_NOR, AF_LOGIC, BR_NONE, PS_SEQ);
                    FN_JR:  ctrl = mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, LG_AND, AF_ARITH, BR_NONE, PS_REG);
                    default: ctrl = '0;
                endcase
            end
            OP_LUI:  ctrl = mk(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, LG_AND, AF_UPPER, BR_NONE, PS_SEQ);
            OP_ADDI: ctrl = mk(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, LG_AND, AF_ARITH, BR_NONE, PS_SEQ);
            OP_SLTI: ctrl = mk(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, LG_AND, AF_SETLT, BR_NONE, PS_SEQ);
            OP_ANDI: ctrl = mk(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, LG_AND, AF_LOGIC, BR_NONE, PS_SEQ);
            OP_ORI:  ctrl = mk(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, LG_OR,  AF_LOGIC, BR_NONE, PS_SEQ);
            OP_XORI: ctrl = mk(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, LG_XOR, AF_LOGIC, BR_NONE, PS_SEQ);
            OP_LW:   ctrl = mk(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, LG_AND, AF_ARITH, BR_NONE, PS_SEQ);
            OP_SW:   ctrl = mk(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, LG_AND, AF_ARITH, BR_NONE, PS_SEQ);
            OP_J:    ctrl = mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, LG_AND, AF_ARITH, BR_NONE, PS_JUMP);
            OP_BLTZ: ctrl = mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, LG_AND, AF_ARITH, BR_LTZ, PS_SEQ);
            OP_BEQ:  ctrl = mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, LG_AND, AF_ARITH, BR_EQ, PS_SEQ);
            OP_BNE:  ctrl = mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, LG_AND, AF_ARITH, BR_NE, PS_SEQ);
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RIDX_W-1:0] rd_addr_a,
    input  logic [RIDX_W-1:0] rd_addr_b,
    output logic [XLEN-1:0]   rd_data_a,
    output logic [XLEN-1:0]   rd_data_b,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_addr,
    input  logic [XLEN-1:0]   wr_data
);

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] regs;
    } rf_state_t;

    rf_state_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (wr_en && (wr_addr != '0)) begin
            rf_d.regs[wr_addr] = wr_data;
        end
        rd_data_a = (rd_addr_a == '0) ? '0 : rf_q.regs[rd_addr_a];
        rd_data_b = (rd_addr_b == '0) ? '0 : rf_q.regs[rd_addr_b];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
(
    input  logic [XLEN-1:0] x,
    input  logic [XLEN-1:0] y,
    input  logic            add_sub,
    input  logic_op_e       logic_op,
    input  alu_fn_e         alu_fn,
    output logic [XLEN-1:0] result,
    output logic            ovf,
    output logic            zero
);

    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] y_eff;
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] lg;
    logic            less;

    always_comb begin
        y_eff = add_sub ? ~y : y;
        sum   = x + y_eff + {{(XLEN-1){1'b0}}, add_sub};
        ovf   = (x[XLEN-1] == y_eff[XLEN-1]) && (sum[XLEN-1] != x[XLEN-1]);
        zero  = (sum == '0);
        less  = sum[XLEN-1] ^ ovf;

        unique case (logic_op)
            LG_AND:  lg = x & y;
            LG_OR:   lg = x | y;
            LG_XOR:  lg = x ^ y;
            default: lg = ~(x | y);
        endcase

        unique case (alu_fn)
            AF_UPPER: result = {y[HALF-1:0], {HALF{1'b0}}};
            AF_SETLT: result = {{(XLEN-1){1'b0}}, less};
            AF_ARITH: result = sum;
            default:  result = lg;
        endcase
    end

endmodule

// File: rtl/sc_dmem.sv
module sc_dmem
    import sc_core_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   addr,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] rd_data
);

    typedef struct packed {
        logic [WORDS-1:0][XLEN-1:0] mem;
    } dm_state_t;

    dm_state_t dm_d, dm_q;

    always_comb begin
        dm_d = dm_q;
        if (wr_en) begin
            dm_d.mem[addr] = wr_data;
        end
        rd_data = dm_q.mem[addr];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            dm_q <= '0;
        end else begin
            dm_q <= dm_d;
        end
    end

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int                        PROG_WORDS = 32,
    parameter int                        DMEM_WORDS = 16,
    parameter int                        DBG_W      = 4,
    parameter logic [PROG_WORDS*ILEN-1:0] PROG      = '0
) (
    input  logic             clk,
    input  logic             rst,
    output logic [DBG_W-1:0] dbg_rs,
    output logic [DBG_W-1:0] dbg_rt,
    output logic [DBG_W-1:0] dbg_pc,
    output logic             ovf_flag,
    output logic             zero_flag
);

    localparam int IMEM_AW = $clog2(PROG_WORDS);
    localparam int DMEM_AW = $clog2(DMEM_WORDS);
    localparam int IMM_W   = 16;
    localparam int TGT_W   = 26;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t state_d, state_q;

    logic [ILEN-1:0] rom [PROG_WORDS];

    for (genvar g = 0; g < PROG_WORDS; g++) begin : g_rom
        assign rom[g] = PROG[g*ILEN +: ILEN];
    end

    logic [ILEN-1:0]   instr;
    logic [5:0]        opcode, funct;
    logic [RIDX_W-1:0] rs_a, rt_a, rd_a, wb_addr;
    logic [IMM_W-1:0]  imm;
    logic [TGT_W-1:0]  tgt;
    logic [XLEN-1:0]   imm_sx, imm_ext, alu_y, alu_res, wb_data;
    logic [XLEN-1:0]   rs_val, rt_val, dm_rdata, pc_inc;
    logic              br_taken, alu_ovf, alu_zero;
    ctrl_t             ctrl;

    always_comb begin
        instr   = (state_q.pc < XLEN'(PROG_WORDS)) ? rom[state_q.pc[IMEM_AW-1:0]] : '0;
        opcode  = instr[31:26];
        rs_a    = instr[25:21];
        rt_a    = instr[20:16];
        rd_a    = instr[15:11];
        funct   = instr[5:0];
        imm     = instr[IMM_W-1:0];
        tgt     = instr[TGT_W-1:0];
        imm_sx  = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        imm_ext = (ctrl.alu_fn == AF_LOGIC) ? {{(XLEN-IMM_W){1'b0}}, imm} : imm_sx;
        alu_y   = ctrl.alu_src ? imm_ext : rt_val;
        wb_data = ctrl.reg_in_src ? alu_res : dm_rdata;
        wb_addr = ctrl.reg_dst ? rd_a : rt_a;
    end

    sc_decode u_decode (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    sc_regfile u_regfile (
        .clk       (clk),
        .rst       (rst),
        .rd_addr_a (rs_a),
        .rd_addr_b (rt_a),
        .rd_data_a (rs_val),
        .rd_data_b (rt_val),
        .wr_en     (ctrl.reg_write),
        .wr_addr   (wb_addr),
        .wr_data   (wb_data)
    );

    sc_alu u_alu (
        .x        (rs_val),
        .y        (alu_y),
        .add_sub  (ctrl.add_sub),
        .logic_op (ctrl.logic_op),
        .alu_fn   (ctrl.alu_fn),
        .result   (alu_res),
        .ovf      (alu_ovf),
        .zero     (alu_zero)
    );

    sc_dmem #(
        .WORDS (DMEM_WORDS)
    ) u_dmem (
        .clk     (clk),
        .rst     (rst),
        .addr    (alu_res[DMEM_AW-1:0]),
        .wr_en   (ctrl.data_write),
        .wr_data (rt_val),
        .rd_data (dm_rdata)
    );

    always_comb begin
        unique case (ctrl.br_kind)
            BR_EQ:   br_taken = (rs_val == rt_val);
            BR_NE:   br_taken = (rs_val != rt_val);
            BR_LTZ:  br_taken = rs_val[XLEN-1];
            default: br_taken = 1'b0;
        endcase

        pc_inc  = state_q.pc + XLEN'(1);
        state_d = state_q;
        unique case (ctrl.pc_src)
            PS_JUMP: state_d.pc = {{(XLEN-TGT_W){1'b0}}, tgt};
            PS_REG:  state_d.pc = rs_val;
            default: state_d.pc = br_taken ? (pc_inc + imm_sx) : pc_inc;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dbg_rs    = rs_val[DBG_W-1:0];
    assign dbg_rt    = rt_val[DBG_W-1:0];
    assign dbg_pc    = state_q.pc[DBG_W-1:0];
    assign ovf_flag  = alu_ovf;
    assign zero_flag = alu_zero;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_core_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc_q,
    input logic [ILEN-1:0] instr,
    input ctrl_t           ctrl,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val,
    input logic            dmem_we
);

    function automatic logic known(input logic [ILEN-1:0] w);
        logic [5:0] op, fn;
        op = w[31:26];
        fn = w[5:0];
        if (op == OP_RTYPE) begin
            return fn inside {FN_ADD, FN_SUB, FN_SLT, FN_AND, FN_OR, FN_XOR, FN_NOR, FN_JR};
        end
        return op inside {OP_LUI, OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI, OP_XORI,
                          OP_LW, OP_SW, OP_J, OP_BLTZ, OP_BEQ, OP_BNE};
    endfunction

    logic [XLEN-1:0] br_target;
    assign br_target = pc_q + XLEN'(1) + {{(XLEN-16){instr[15]}}, instr[15:0]};

    always @(negedge clk) begin
        if (rst) begin
            p_reset_pc_r1: assert (pc_q == '0);
        end
    end

    p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl.pc_src == PS_SEQ && ctrl.br_kind == BR_NONE) |=> pc_q == $past(pc_q) + XLEN'(1));

    p_r0_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == 5'd0) |-> (rs_val == '0));

    p_store_only_sw_r7: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (instr[31:26] == OP_SW));

    p_beq_taken_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.br_kind == BR_EQ && rs_val == rt_val) |=> pc_q == $past(br_target));

    p_jump_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl.pc_src == PS_JUMP) |=> pc_q == $past({6'b0, instr[25:0]}));

    p_jreg_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl.pc_src == PS_REG) |=> pc_q == $past(rs_val));

    p_unknown_noop_r10: assert property (@(posedge clk) disable iff (rst)
        !known(instr) |-> (!ctrl.reg_write && !ctrl.data_write
                           && ctrl.pc_src == PS_SEQ && ctrl.br_kind == BR_NONE));

endmodule

bind sc_core sc_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc_q    (state_q.pc),
    .instr   (instr),
    .ctrl    (ctrl),
    .rs_val  (rs_val),
    .rt_val  (rt_val),
    .dmem_we (ctrl.data_write)
);

// File: tb/sc_core_test.sv
module sc_core_test;

    localparam int NW = 40;

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] tgt);
        return {op, tgt};
    endfunction

    function automatic logic [NW*32-1:0] build_prog();
        logic [NW*32-1:0] p;
        logic [31:0]      poison;
        p      = '0;
        poison = enc_i(6'h08, 5'd0, 5'd20, 16'd1);
        p[ 0*32 +: 32] = enc_i(6'h0F, 5'd0,  5'd1,  16'h7FFF);
        p[ 1*32 +: 32] = enc_i(6'h0D, 5'd1,  5'd1,  16'hFFFF);
        p[ 2*32 +: 32] = enc_i(6'h08, 5'd0,  5'd2,  16'd5);
        p[ 3*32 +: 32] = enc_i(6'h08, 5'd1,  5'd3,  16'd1);
        p[ 4*32 +: 32] = enc_r(5'd2,  5'd2,  5'd4,  6'h20);
        p[ 5*32 +: 32] = enc_r(5'd2,  5'd2,  5'd5,  6'h22);
        p[ 6*32 +: 32] = enc_r(5'd3,  5'd2,  5'd6,  6'h22);
        p[ 7*32 +: 32] = enc_r(5'd3,  5'd2,  5'd7,  6'h2A);
        p[ 8*32 +: 32] = enc_i(6'h0A, 5'd2,  5'd8,  16'hFFFD);
        p[ 9*32 +: 32] = enc_i(6'h0E, 5'd0,  5'd9,  16'h8003);
        p[10*32 +: 32] = enc_i(6'h01, 5'd9,  5'd0,  16'd5);
        p[11*32 +: 32] = enc_r(5'd4,  5'd9,  5'd10, 6'h24);
        p[12*32 +: 32] = enc_r(5'd4,  5'd2,  5'd11, 6'h25);
        p[13*32 +: 32] = enc_r(5'd0,  5'd0,  5'd12, 6'h27);
        p[14*32 +: 32] = enc_r(5'd11, 5'd4,  5'd13, 6'h26);
        p[15*32 +: 32] = enc_i(6'h01, 5'd12, 5'd0,  16'd2);
        p[16*32 +: 32] = poison;
        p[17*32 +: 32] = poison;
        p[18*32 +: 32] = enc_i(6'h2B, 5'd2,  5'd4,  16'd3);
        p[19*32 +: 32] = enc_i(6'h23, 5'd2,  5'd14, 16'd3);
        p[20*32 +: 32] = enc_i(6'h04, 5'd14, 5'd4,  16'd2);
        p[21*32 +: 32] = poison;
        p[22*32 +: 32] = poison;
        p[23*32 +: 32] = enc_i(6'h05, 5'd14, 5'd20, 16'd1);
        p[24*32 +: 32] = poison;
        p[25*32 +: 32] = enc_i(6'h04, 5'd2,  5'd4,  16'd3);
        p[26*32 +: 32] = enc_i(6'h08, 5'd0,  5'd0,  16'd7);
        p[27*32 +: 32] = enc_r(5'd0,  5'd14, 5'd15, 6'h20);
        p[28*32 +: 32] = enc_i(6'h3F, 5'd8,  5'd16, 16'h1234);
        p[29*32 +: 32] = enc_r(5'd10, 5'd13, 5'd17, 6'h01);
        p[30*32 +: 32] = enc_i(6'h08, 5'd0,  5'd18, 16'd35);
        p[31*32 +: 32] = enc_j(6'h02, 26'd33);
        p[32*32 +: 32] = poison;
        p[33*32 +: 32] = enc_r(5'd18, 5'd0,  5'd0,  6'h08);
        p[34*32 +: 32] = poison;
        p[35*32 +: 32] = enc_r(5'd16, 5'd17, 5'd19, 6'h20);
        p[36*32 +: 32] = enc_r(5'd20, 5'd7,  5'd21, 6'h20);
        p[37*32 +: 32] = enc_j(6'h02, 26'd37);
        return p;
    endfunction

    localparam logic [NW*32-1:0] PROG = build_prog();

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] dbg_rs, dbg_rt, dbg_pc;
    logic       ovf_flag, zero_flag;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #10 clk = ~clk;

    sc_core #(
        .PROG_WORDS (NW),
        .DMEM_WORDS (16),
        .DBG_W      (4),
        .PROG       (PROG)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .dbg_rs    (dbg_rs),
        .dbg_rt    (dbg_rt),
        .dbg_pc    (dbg_pc),
        .ovf_flag  (ovf_flag),
        .zero_flag (zero_flag)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic look(input string req, input int pc, input logic [3:0] rs_e,
                        input logic [3:0] rt_e);
        chk(req, $sformatf("pc at word %0d", pc), 32'(dbg_pc), 32'(pc[3:0]));
        chk(req, $sformatf("rs port at word %0d", pc), 32'(dbg_rs), 32'(rs_e));
        chk(req, $sformatf("rt port at word %0d", pc), 32'(dbg_rt), 32'(rt_e));
    endtask

    task automatic flags(input string req, input logic ovf_e, input logic zero_e);
        chk(req, "overflow flag", 32'(ovf_flag), 32'(ovf_e));
        chk(req, "zero flag", 32'(zero_flag), 32'(zero_e));
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic run_at(input string req, input int pc, input logic [3:0] rs_e,
                          input logic [3:0] rt_e);
        look(req, pc, rs_e, rt_e);
        step();
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        #1;
        chk("R1", "pc held in reset", 32'(dbg_pc), 32'h0);
        rst = 1'b0;
        #1;
        look("R1", 0, 4'h0, 4'h0);
    endtask

    task automatic t_immediates();
        run_at("R5", 0, 4'h0, 4'h0);
        run_at("R5", 1, 4'h0, 4'h0);
        run_at("R5", 2, 4'h0, 4'h0);
        flags("R3", 1'b1, 1'b0);
        run_at("R5", 3, 4'hF, 4'h0);
    endtask

    task automatic t_arith();
        flags("R3", 1'b0, 1'b0);
        run_at("R3", 4, 4'h5, 4'h5);
        flags("R3", 1'b0, 1'b1);
        run_at("R3", 5, 4'h5, 4'h5);
        flags("R3", 1'b1, 1'b0);
        run_at("R3", 6, 4'h0, 4'h5);
        flags("R3", 1'b1, 1'b0);
        run_at("R3", 7, 4'h0, 4'h5);
        run_at("R5", 8, 4'h5, 4'h0);
    endtask

    task automatic t_logic();
        run_at("R5", 9, 4'h0, 4'h0);
        run_at("R5", 10, 4'h3, 4'h0);
        run_at("R4", 11, 4'hA, 4'h3);
        run_at("R4", 12, 4'hA, 4'h5);
        run_at("R4", 13, 4'h0, 4'h0);
        run_at("R4", 14, 4'hF, 4'hA);
        run_at("R8", 15, 4'hF, 4'h0);
    endtask

    task automatic t_memory();
        run_at("R7", 18, 4'h5, 4'hA);
        run_at("R7", 19, 4'h5, 4'h0);
    endtask

    task automatic t_branches();
        flags("R8", 1'b0, 1'b1);
        run_at("R8", 20, 4'hA, 4'hA);
        run_at("R8", 23, 4'hA, 4'h0);
        flags("R8", 1'b0, 1'b0);
        run_at("R8", 25, 4'h5, 4'hA);
    endtask

    task automatic t_noops();
        run_at("R6", 26, 4'h0, 4'h0);
        run_at("R6", 27, 4'h0, 4'hA);
        run_at("R10", 28, 4'h0, 4'h0);
        run_at("R11", 29, 4'h2, 4'h5);
    endtask

    task automatic t_jumps();
        run_at("R9", 30, 4'h0, 4'h0);
        run_at("R9", 31, 4'h0, 4'h0);
        run_at("R9", 33, 4'h3, 4'h0);
        run_at("R10", 35, 4'h0, 4'h0);
        run_at("R11", 36, 4'h0, 4'h1);
        run_at("R9", 37, 4'h0, 4'h0);
        look("R9", 37, 4'h0, 4'h0);
    endtask

    task automatic t_async_reset();
        rst = 1'b1;
        #2;
        look("R1", 0, 4'h0, 4'h0);
        @(negedge clk);
        #1;
        rst = 1'b0;
        #1;
        run_at("R1", 0, 4'h0, 4'h0);
        run_at("R2", 1, 4'h0, 4'h0);
        look("R2", 2, 4'h0, 4'h0);
    endtask

    initial begin
        t_reset();
        t_immediates();
        t_arith();
        t_logic();
        t_memory();
        t_branches();
        t_noops();
        t_jumps();
        t_async_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule